// File: doc/BRIEF.md
# Dual-Tone Period-Counting Frequency Classifier

This block sits behind the analog band-split filters and limiters of a touch-tone receiver. It takes two 1-bit square waves, one carrying the low-band tone and one the high-band tone, and times each wave in reference clock cycles. The time from one rising edge to the next is its period. Each period is matched against four precomputed count windows per band, one for each signalling frequency. A band is declared valid only once a run of consecutive periods has landed in the same window.

While both bands are valid together, the block raises an early-steer flag. It also latches the row index (low band) and the column index (high band), and keeps them until a new pair is registered. A band that stops producing edges for longer than its slowest valid period is dropped at once. An inhibit input removes the highest column frequency from the set of accepted tones. The period windows come from the reference clock frequency and a tolerance in parts per thousand. Both are parameters. The defaults are a 3.579545 MHz clock, a ±2.5% window and four periods.

Top module: `dtmf_period_classifier`

## Requirements
- R1: After reset, `early_steer` is 0 and `row_idx` and `col_idx` are both 0.
- R2: A period is the number of clock cycles between two consecutive rising edges of a band input. A low-band period falls in the window of tone k if the frequency it implies is within ±2.5% of that tone's nominal value. The low tones are 697, 770, 852 and 941 Hz, giving row codes 0 to 3. So any tone within ±1.5% ±2 Hz of nominal is accepted.
- R3: High-band periods are classified the same way against 1209, 1336, 1477 and 1633 Hz, giving column codes 0 to 3.
- R4: A period that falls in no window clears that band's run and valid state. So a tone that is 3.5% or more away from every nominal frequency is never accepted.
- R5: The first rising edge after reset or after a timeout gives no measurement. A band becomes valid only on the 4th consecutive in-window period of the same tone. That rising edge is sampled at clock edge s, and `early_steer` can then rise after clock edge s+4 at the earliest.
- R6: A period that falls in a different window from the current candidate restarts the run at one. So a wave alternating between two tone periods never becomes valid.
- R7: `early_steer` is 1 exactly one cycle after both bands are valid. It falls one cycle after either band loses validity, for example when the tone changes.
- R8: A band whose counter passes the longest accepted period of its slowest tone, with no rising edge, is invalidated at once. The bench sees this as no rising edge for more than 527 cycles (low band) or 304 cycles (high band) at a 357954 Hz parameter setting.
- R9: While `inhibit_top` is 1, a high-band period in the 1633 Hz window counts as out of window. A column 3 that is already valid is dropped within one cycle of the inhibit rising.
- R10: `row_idx` and `col_idx` change only when both bands are valid. Otherwise they hold the last registered pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_sq | input | 1 | Limited low-band square wave |
| high_sq | input | 1 | Limited high-band square wave |
| inhibit_top | input | 1 | Removes the 1633 Hz column while high |
| early_steer | output | 1 | Both bands hold valid tones |
| row_idx | output | 2 | Low-band code of the last registered pair |
| col_idx | output | 2 | High-band code of the last registered pair |

## Verification
Two things can happen at the same clock edge. One band's validity is cleared by a restart, a reject or a timeout, while the steering stage registers the pair it saw on the previous cycle. The bench provokes this by switching one band to a new tone while the other band stays valid. The old pair is latched, then `early_steer` drops, and the new pair appears only after four fresh periods. A behavioural model built on queues and integer edge times predicts `early_steer`, `row_idx` and `col_idx` on every clock. Any cycle where they disagree counts as a failure.

// File: rtl/dtmf_pc_pkg.sv
package dtmf_pc_pkg;

  // Nominal tone frequency in Hz, group 0 = rows, group 1 = columns
  function automatic int unsigned tone_hz(input bit high_grp, input int unsigned k);
    int unsigned f;
    if (!high_grp) begin
      case (k)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (k)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // floor(clk_hz * 1000 / (f_hz * scale_permille))
  function automatic int unsigned count_floor(input int unsigned clk_hz,
                                              input int unsigned f_hz,
                                              input int unsigned scale_permille);
    logic [63:0] num;
    logic [63:0] den;
    num = 64'(clk_hz) * 64'd1000;
    den = 64'(f_hz) * 64'(scale_permille);
    return 32'(num / den);
  endfunction

  // shortest accepted period (highest accepted frequency)
  function automatic int unsigned win_lo(input int unsigned clk_hz, input int unsigned f_hz,
                                         input int unsigned tol);
    return count_floor(clk_hz, f_hz, 1000 + tol);
  endfunction

  // longest accepted period (lowest accepted frequency)
  function automatic int unsigned win_hi(input int unsigned clk_hz, input int unsigned f_hz,
                                         input int unsigned tol);
    return count_floor(clk_hz, f_hz, 1000 - tol);
  endfunction

  // count at which a silent band is dropped
  function automatic int unsigned timeout_lim(input int unsigned clk_hz, input bit high_grp,
                                              input int unsigned tol);
    return win_hi(clk_hz, tone_hz(high_grp, 0), tol) + 1;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned clk_hz, input int unsigned tol);
    return $clog2(timeout_lim(clk_hz, 1'b0, tol) + 1);
  endfunction

endpackage

// File: rtl/dtmf_edge_timer.sv
module dtmf_edge_timer #(
  parameter int unsigned CLK_HZ       = 3579545,
  parameter int unsigned TOL_PERMILLE = 25,
  parameter bit          HIGH_GRP     = 1'b0,
  parameter int unsigned CNT_W        = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tone_in,
  output logic             meas_stb,
  output logic             tmo_stb,
  output logic [CNT_W-1:0] meas_cnt
);
  localparam int unsigned    LIM   = dtmf_pc_pkg::timeout_lim(CLK_HZ, HIGH_GRP, TOL_PERMILLE);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIM);

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             have_ref_q;
  logic             rise_seen;

  assign rise_seen = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q     <= '0;
      cnt_q      <= '0;
      have_ref_q <= 1'b0;
      meas_stb   <= 1'b0;
      tmo_stb    <= 1'b0;
      meas_cnt   <= '0;
    end else begin
      sync_q   <= {sync_q[1:0], tone_in};
      meas_stb <= 1'b0;
      tmo_stb  <= 1'b0;
      if (rise_seen) begin
        cnt_q      <= CNT_W'(1);
        have_ref_q <= 1'b1;
        if (have_ref_q) begin
          meas_stb <= 1'b1;
          meas_cnt <= cnt_q;
        end
      end else if (have_ref_q) begin
        if (cnt_q == LIM_C) begin
          tmo_stb    <= 1'b1;
          have_ref_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_event_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_stb && tmo_stb));
  assert_no_meas_after_tmo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_stb |=> !meas_stb);
  assert_meas_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb |-> (meas_cnt >= CNT_W'(2) && meas_cnt <= LIM_C));

endmodule

// File: rtl/dtmf_band_judge.sv
module dtmf_band_judge #(
  parameter int unsigned CLK_HZ       = 3579545,
  parameter int unsigned TOL_PERMILLE = 25,
  parameter bit          HIGH_GRP     = 1'b0,
  parameter int unsigned CNT_W        = 13,
  parameter int unsigned RUN_NEED     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_stb,
  input  logic             tmo_stb,
  input  logic [CNT_W-1:0] meas_cnt,
  input  logic             mask_top,
  output logic             band_valid,
  output logic [1:0]       band_idx
);
  localparam int unsigned RUN_W = $clog2(RUN_NEED + 1);

  logic [3:0]       in_win;
  logic             hit;
  logic [1:0]       hit_idx;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_inc;
  logic [1:0]       cand_q;
  logic             same_tone;

  for (genvar k = 0; k < 4; k++) begin : g_win
    localparam int unsigned LO =
      dtmf_pc_pkg::win_lo(CLK_HZ, dtmf_pc_pkg::tone_hz(HIGH_GRP, k), TOL_PERMILLE);
    localparam int unsigned HI =
      dtmf_pc_pkg::win_hi(CLK_HZ, dtmf_pc_pkg::tone_hz(HIGH_GRP, k), TOL_PERMILLE);
    if (k == 3) begin : g_maskable
      assign in_win[k] = ~mask_top & (meas_cnt >= CNT_W'(LO)) & (meas_cnt <= CNT_W'(HI));
    end else begin : g_plain
      assign in_win[k] = (meas_cnt >= CNT_W'(LO)) & (meas_cnt <= CNT_W'(HI));
    end
  end

  always_comb begin
    hit_idx = 2'd0;
    for (int k = 3; k >= 0; k--) begin
      if (in_win[k]) hit_idx = 2'(k);
    end
  end

  assign hit       = |in_win;
  assign same_tone = hit && (hit_idx == cand_q) && (run_q != '0);
  assign run_inc   = (run_q == RUN_W'(RUN_NEED)) ? run_q : run_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q      <= '0;
      cand_q     <= 2'd0;
      band_valid <= 1'b0;
    end else if (tmo_stb) begin
      run_q      <= '0;
      band_valid <= 1'b0;
    end else if (meas_stb) begin
      if (same_tone) begin
        run_q      <= run_inc;
        band_valid <= (run_inc >= RUN_W'(RUN_NEED));
      end else if (hit) begin
        cand_q     <= hit_idx;
        run_q      <= RUN_W'(1);
        band_valid <= (RUN_NEED <= 1);
      end else begin
        run_q      <= '0;
        band_valid <= 1'b0;
      end
    end else if (mask_top && cand_q == 2'd3) begin
      run_q      <= '0;
      band_valid <= 1'b0;
    end
  end

  assign band_idx = cand_q;

  assert_tmo_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_stb |=> !band_valid);
  assert_reject_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && !hit) |=> !band_valid);
  assert_rise_on_meas_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(band_valid) |-> $past(meas_stb));
  assert_mask_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_top) && band_valid) |-> (band_idx != 2'd3));

endmodule

// File: rtl/dtmf_pair_steer.sv
module dtmf_pair_steer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       low_valid,
  input  logic [1:0] low_idx,
  input  logic       high_valid,
  input  logic [1:0] high_idx,
  output logic       early_steer,
  output logic [1:0] row_idx,
  output logic [1:0] col_idx
);
  logic both_ok;

  assign both_ok = low_valid & high_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      early_steer <= 1'b0;
      row_idx     <= 2'd0;
      col_idx     <= 2'd0;
    end else begin
      early_steer <= both_ok;
      if (both_ok) begin
        row_idx <= low_idx;
        col_idx <= high_idx;
      end
    end
  end

  assert_steer_needs_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    early_steer |-> $past(low_valid && high_valid));
  assert_steer_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_valid || !high_valid) |=> !early_steer);
  assert_pair_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !both_ok |=> ($stable(row_idx) && $stable(col_idx)));

endmodule

// File: rtl/dtmf_period_classifier.sv
module dtmf_period_classifier #(
  parameter int unsigned CLK_HZ       = 3579545,
  parameter int unsigned TOL_PERMILLE = 25,
  parameter int unsigned RUN_NEED     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       low_sq,
  input  logic       high_sq,
  input  logic       inhibit_top,
  output logic       early_steer,
  output logic [1:0] row_idx,
  output logic [1:0] col_idx
);
  localparam int unsigned CNT_W = dtmf_pc_pkg::cnt_bits(CLK_HZ, TOL_PERMILLE);

  logic [1:0]       sq_in;
  logic [1:0]       band_mask;
  logic [1:0]       b_meas;
  logic [1:0]       b_tmo;
  logic [1:0]       b_valid;
  logic [CNT_W-1:0] b_cnt [2];
  logic [1:0]       b_idx [2];

  assign sq_in     = {high_sq, low_sq};
  assign band_mask = {inhibit_top, 1'b0};

  for (genvar g = 0; g < 2; g++) begin : g_band
    dtmf_edge_timer #(
      .CLK_HZ(CLK_HZ), .TOL_PERMILLE(TOL_PERMILLE), .HIGH_GRP(g == 1), .CNT_W(CNT_W)
    ) u_timer (
      .clk(clk), .rst_n(rst_n), .tone_in(sq_in[g]),
      .meas_stb(b_meas[g]), .tmo_stb(b_tmo[g]), .meas_cnt(b_cnt[g])
    );
    dtmf_band_judge #(
      .CLK_HZ(CLK_HZ), .TOL_PERMILLE(TOL_PERMILLE), .HIGH_GRP(g == 1), .CNT_W(CNT_W),
      .RUN_NEED(RUN_NEED)
    ) u_judge (
      .clk(clk), .rst_n(rst_n), .meas_stb(b_meas[g]), .tmo_stb(b_tmo[g]),
      .meas_cnt(b_cnt[g]), .mask_top(band_mask[g]),
      .band_valid(b_valid[g]), .band_idx(b_idx[g])
    );
  end

  dtmf_pair_steer u_steer (
    .clk(clk), .rst_n(rst_n),
    .low_valid(b_valid[0]), .low_idx(b_idx[0]),
    .high_valid(b_valid[1]), .high_idx(b_idx[1]),
    .early_steer(early_steer), .row_idx(row_idx), .col_idx(col_idx)
  );

endmodule

// File: tb/dtmf_period_classifier_test.sv
module dtmf_period_classifier_test;
  localparam int unsigned CLKHZ = 357954;
  localparam int NEED = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic low_sq = 1'b0;
  logic high_sq = 1'b0;
  logic inhibit = 1'b0;
  logic est;
  logic [1:0] row;
  logic [1:0] col;

  always #5 clk = ~clk;

  dtmf_period_classifier #(.CLK_HZ(CLKHZ), .TOL_PERMILLE(25), .RUN_NEED(NEED)) uut (
    .clk(clk), .rst_n(rst_n), .low_sq(low_sq), .high_sq(high_sq),
    .inhibit_top(inhibit), .early_steer(est), .row_idx(row), .col_idx(col)
  );

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R1";
  bit finished = 1'b0;

  // ---------------- stimulus generator ----------------
  int per[2];
  int alt[2];
  int cur[2];
  int ph[2];

  initial begin
    per = '{0, 0}; alt = '{0, 0}; cur = '{0, 0}; ph = '{0, 0};
    forever begin
      @(negedge clk);
      for (int b = 0; b < 2; b++) begin
        logic v;
        if (per[b] == 0) begin
          ph[b] = 0; cur[b] = 0; v = 1'b0;
        end else begin
          ph[b] = ph[b] + 1;
          if (ph[b] >= cur[b]) begin
            ph[b] = 0;
            if (alt[b] != 0 && cur[b] == per[b]) cur[b] = alt[b];
            else cur[b] = per[b];
          end
          v = (ph[b] < cur[b] / 2);
        end
        if (b == 0) low_sq = v; else high_sq = v;
      end
    end
  end

  // ---------------- behavioural reference ----------------
  int lim[2];
  int m_prev[2], m_ref[2], m_last[2];
  int m_run[2], m_cand[2], m_val[2];
  int m_est, m_row, m_col;
  int s_idx;
  int q_lo[$];
  int q_hi[$];

  function automatic int per_of(real f);
    return $rtoi(real'(CLKHZ) / f + 0.5);
  endfunction

  function automatic int classify(int b, int p, bit m);
    real f;
    real nom;
    f = real'(CLKHZ) / real'(p);
    for (int k = 0; k < 4; k++) begin
      if (b == 0) nom = (k == 0) ? 697.0 : (k == 1) ? 770.0 : (k == 2) ? 852.0 : 941.0;
      else        nom = (k == 0) ? 1209.0 : (k == 1) ? 1336.0 : (k == 2) ? 1477.0 : 1633.0;
      if (!(b == 1 && k == 3 && m) && f >= nom * 0.975 && f <= nom * 1.025) return k;
    end
    return -1;
  endfunction

  task automatic judge_model(int b, int ev, bit m);
    int k;
    if (ev < 0) begin
      m_run[b] = 0; m_val[b] = 0;
    end else if (ev > 0) begin
      k = classify(b, ev, m);
      if (k >= 0) begin
        if (k == m_cand[b] && m_run[b] > 0) begin
          m_run[b] = (m_run[b] + 1 > NEED) ? NEED : m_run[b] + 1;
        end else begin
          m_cand[b] = k; m_run[b] = 1;
        end
        m_val[b] = (m_run[b] >= NEED);
      end else begin
        m_run[b] = 0; m_val[b] = 0;
      end
    end else if (b == 1 && m && m_cand[b] == 3) begin
      m_run[b] = 0; m_val[b] = 0;
    end
  endtask

  initial begin
    lim[0] = $rtoi($floor(real'(CLKHZ) / (697.0 * 0.975))) + 1;
    lim[1] = $rtoi($floor(real'(CLKHZ) / (1209.0 * 0.975))) + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        m_prev[b] = 0; m_ref[b] = 0; m_last[b] = 0;
        m_run[b] = 0; m_cand[b] = 0; m_val[b] = 0;
      end
      m_est = 0; m_row = 0; m_col = 0; s_idx = 0;
      q_lo.delete(); q_hi.delete();
      for (int i = 0; i < 3; i++) begin
        q_lo.push_back(0); q_hi.push_back(0);
      end
    end else begin
      int ev_lo;
      int ev_hi;
      for (int b = 0; b < 2; b++) begin
        int c;
        int ev;
        c = (b == 0) ? int'(low_sq) : int'(high_sq);
        ev = 0;
        if (c == 1 && m_prev[b] == 0) begin
          if (m_ref[b] != 0) ev = s_idx - m_last[b];
          m_ref[b] = 1; m_last[b] = s_idx;
        end else if (m_ref[b] != 0 && s_idx - m_last[b] == lim[b]) begin
          ev = -1; m_ref[b] = 0;
        end
        m_prev[b] = c;
        if (b == 0) q_lo.push_back(ev); else q_hi.push_back(ev);
      end
      if (m_val[0] != 0 && m_val[1] != 0) begin
        m_est = 1; m_row = m_cand[0]; m_col = m_cand[1];
      end else begin
        m_est = 0;
      end
      ev_lo = q_lo.pop_front();
      ev_hi = q_hi.pop_front();
      judge_model(0, ev_lo, inhibit);
      judge_model(1, ev_hi, inhibit);
      s_idx++;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_checks++;
      if (int'(est) != m_est || int'(row) != m_row || int'(col) != m_col) begin
        n_fail++;
        $display("FAIL %s model compare at %0t: actual est=%0d row=%0d col=%0d expected est=%0d row=%0d col=%0d",
                 tag, $time, est, row, col, m_est, m_row, m_col);
      end
    end
  end

  task automatic check_out(string rq, int e, int r, int c);
    n_checks++;
    if (int'(est) != e || int'(row) != r || int'(col) != c) begin
      n_fail++;
      $display("FAIL %s: actual est=%0d row=%0d col=%0d expected est=%0d row=%0d col=%0d",
               rq, est, row, col, e, r, c);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1", 0, 0, 0);

    // R5: fresh start, valid only after the fourth full period
    tag = "R5";
    per[0] = per_of(941.0); per[1] = per_of(1209.0);
    wait_n(1400);
    check_out("R5", 0, 0, 0);
    wait_n(300);
    check_out("R5", 1, 3, 0);

    // R3 nominal pair
    tag = "R3";
    per[0] = per_of(852.0); per[1] = per_of(1336.0);
    wait_n(3500);
    check_out("R3", 1, 2, 1);

    // R2 deviated but acceptable
    tag = "R2";
    per[0] = per_of(697.0 * 1.015 + 2.0); per[1] = per_of(1336.0 * 0.985 - 2.0);
    wait_n(3500);
    check_out("R2", 1, 0, 1);
    per[0] = per_of(941.0 * 0.985 - 2.0); per[1] = per_of(1477.0 * 1.015 + 2.0);
    wait_n(3500);
    check_out("R2", 1, 3, 2);

    // R4 rejects, R10 hold
    tag = "R4";
    per[0] = per_of(770.0 * 1.04); per[1] = per_of(1477.0);
    wait_n(3500);
    check_out("R4", 0, 3, 2);
    per[0] = per_of(770.0); per[1] = per_of(1477.0 * 0.96);
    wait_n(3500);
    check_out("R10", 0, 3, 2);

    // R6 alternating periods never settle
    tag = "R6";
    per[0] = per_of(770.0); alt[0] = per_of(852.0); per[1] = per_of(1209.0);
    wait_n(2000);
    check_out("R6", 0, 3, 2);
    wait_n(2000);
    check_out("R6", 0, 3, 2);
    alt[0] = 0;

    // R9 inhibit of the top column
    tag = "R9";
    inhibit = 1'b1;
    per[0] = per_of(852.0); per[1] = per_of(1633.0);
    wait_n(3500);
    check_out("R9", 0, 3, 2);
    inhibit = 1'b0;
    wait_n(3000);
    check_out("R9", 1, 2, 3);
    inhibit = 1'b1;
    wait_n(3);
    check_out("R9", 0, 2, 3);
    inhibit = 1'b0;

    // R8 timeout of a silent band
    tag = "R8";
    per[0] = per_of(697.0); per[1] = per_of(1209.0);
    wait_n(3500);
    check_out("R8", 1, 0, 0);
    per[1] = 0;
    wait_n(500);
    check_out("R8", 0, 0, 0);

    // R7 tone change drops and re-raises the flag
    tag = "R7";
    per[1] = per_of(1209.0);
    wait_n(3500);
    check_out("R7", 1, 0, 0);
    per[0] = per_of(941.0);
    wait_n(3500);
    check_out("R7", 1, 3, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule